// File: doc/BRIEF.md
# Adaptive Slope Delta Codec

This block is an all-digital adaptive delta modulation encoder with a matching decoder. On each encoder sample enable it compares a signed PCM input word with a running estimate held in an integrator. It emits one bit that says whether the estimate has to rise (1) or fall (0). The estimate then moves by an adaptive step in that direction.

The step size depends on a short register of the most recent coded bits. When every bit in the register is the same, the input is outrunning the estimate and the step doubles. Otherwise the step halves. The step is always kept between a minimum and a maximum that are set by parameters. The integrator saturates at the signed full-scale limits and does not wrap.

The decoder holds an identical history, step and integrator path. It is driven only by the received bits, so a decoder that gets the same bit sequence reproduces the encoder's estimate exactly. Both halves are built from one shared tracking module.

Top module: `slope_codec`

## Requirements
- R1: A synchronous active-high reset sets both integrators to 0, both steps to the minimum (STEP_MIN, default 16) and both bit histories to all zeros. It also sets `tx_bit` to 0.
- R2: On each cycle with `enc_en` high, the encoder registers exactly one bit on `tx_bit`. That bit is 1 when the signed `pcm_in` is greater than or equal to the current encoder estimate, and 0 otherwise.
- R3: On each enable, the estimate moves by the newly computed step. It goes up when the coded bit is 1 and down when it is 0.
- R4: The history holds the last HIST coded bits, with the newest in bit 0 (default 3). When the updated history is all ones or all zeros, the step doubles, limited to STEP_MAX (default 4096).
- R5: When the updated history holds both values, the step halves, limited below by STEP_MIN.
- R6: The integrators saturate at +32767 and -32768 (for DATA_W = 16) and never wrap.
- R7: In cycles without the relevant enable, `tx_bit`, `enc_est` and `dec_out` keep their values whatever `pcm_in` and `rx_bit` do.
- R8: The decoder updates on `dec_en` using `rx_bit` under the same rules as R3 to R6. Fed the encoder's bit sequence, `dec_out` equals `enc_est` bit for bit.
- R9: With a constant input of 0 after reset, the coded bits alternate between 1 and 0 on every sample.
- R10: For a slow input ramp (8 LSB per sample), `dec_out` stays within 200 LSB of the input once it has settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_en | input | 1 | Encoder sample enable |
| pcm_in | input | DATA_W | Signed input sample |
| tx_bit | output | 1 | Coded bit, 1 = step up |
| enc_est | output | DATA_W | Encoder integrator (signed) |
| dec_en | input | 1 | Decoder sample enable |
| rx_bit | input | 1 | Received coded bit |
| dec_out | output | DATA_W | Decoder reconstruction (signed) |

## Verification
The assertions assume that reset is held for at least one clock before any enable. They also assume that STEP_MAX stays below half of full scale, so one step can never carry the estimate past saturation by more than one word width. The stimulus only uses legal signed words, pulses each enable for a single cycle, and always starts a test run from reset. The decoder is fed the encoder's own bit one cycle later, so the assertions see the two integrators receive identical bit sequences.

// File: rtl/codec_pkg.sv
package codec_pkg;
    typedef enum logic [0:0] {
        TR_SHRINK = 1'b0,
        TR_GROW   = 1'b1
    } trend_t;
endpackage

// File: rtl/slope_track.sv
module slope_track
    import codec_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int HIST     = 3,
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 4096
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     dir,
    output logic signed [DATA_W-1:0] est
);
    localparam logic [DATA_W-1:0] SMIN_V = DATA_W'(STEP_MIN);
    localparam logic [DATA_W-1:0] SMAX_V = DATA_W'(STEP_MAX);
    localparam logic [DATA_W-1:0] HALF_MAX_V = DATA_W'(STEP_MAX / 2);
    localparam logic signed [DATA_W:0] POS_LIM = {2'b00, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W:0] NEG_LIM = {2'b11, {(DATA_W-1){1'b0}}};

    logic [HIST-1:0]          hist, hist_n;
    logic [DATA_W-1:0]        step, step_n;
    logic signed [DATA_W:0]   acc;
    logic signed [DATA_W-1:0] est_n;
    trend_t                   trend;

    always_comb begin
        hist_n = {hist[HIST-2:0], dir};
        trend  = ((&hist_n) || (~|hist_n)) ? TR_GROW : TR_SHRINK;
        unique case (trend)
            TR_GROW:   step_n = (step > HALF_MAX_V) ? SMAX_V : (step << 1);
            TR_SHRINK: step_n = ((step >> 1) < SMIN_V) ? SMIN_V : (step >> 1);
            default:   step_n = SMIN_V;
        endcase
        if (dir) acc = {est[DATA_W-1], est} + $signed({1'b0, step_n});
        else     acc = {est[DATA_W-1], est} - $signed({1'b0, step_n});
        if (acc > POS_LIM)      est_n = POS_LIM[DATA_W-1:0];
        else if (acc < NEG_LIM) est_n = NEG_LIM[DATA_W-1:0];
        else                    est_n = acc[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            step <= SMIN_V;
            est  <= '0;
        end else if (en) begin
            hist <= hist_n;
            step <= step_n;
            est  <= est_n;
        end
    end

    // R4 / R5: step stays inside its clamp range
    a_r4_step_range: assert property (@(posedge clk) disable iff (rst)
        (step >= SMIN_V) && (step <= SMAX_V));
    // R3: an up bit never lowers the estimate
    a_r3_up_moves_up: assert property (@(posedge clk) disable iff (rst)
        (en && dir) |=> (est >= $past(est)));
    // R3: a down bit never raises the estimate
    a_r3_down_moves_down: assert property (@(posedge clk) disable iff (rst)
        (en && !dir) |=> (est <= $past(est)));
    // R7: no enable, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(est) && $stable(step) && $stable(hist)));
endmodule

// File: rtl/slope_enc.sv
module slope_enc #(
    parameter int DATA_W   = 16,
    parameter int HIST     = 3,
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 4096
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] pcm_in,
    output logic                     bit_out,
    output logic signed [DATA_W-1:0] est
);
    logic dir;

    assign dir = (pcm_in >= est);

    slope_track #(
        .DATA_W(DATA_W), .HIST(HIST), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
    ) u_track (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .est(est)
    );

    always_ff @(posedge clk) begin
        if (rst)     bit_out <= 1'b0;
        else if (en) bit_out <= dir;
    end

    // R2: emitted bit reflects the comparison made at the enable
    a_r2_bit_sign: assert property (@(posedge clk) disable iff (rst)
        en |=> (bit_out == ($past(pcm_in) >= $past(est))));
    // R7: bit held between enables
    a_r7_bit_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(bit_out));
endmodule

// File: rtl/slope_dec.sv
module slope_dec #(
    parameter int DATA_W   = 16,
    parameter int HIST     = 3,
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 4096
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     bit_in,
    output logic signed [DATA_W-1:0] recon
);
    slope_track #(
        .DATA_W(DATA_W), .HIST(HIST), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
    ) u_track (
        .clk(clk), .rst(rst), .en(en), .dir(bit_in), .est(recon)
    );
endmodule

// File: rtl/slope_codec.sv
module slope_codec #(
    parameter int DATA_W   = 16,
    parameter int HIST     = 3,
    parameter int STEP_MIN = 16,
    parameter int STEP_MAX = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_en,
    input  logic [DATA_W-1:0] pcm_in,
    output logic              tx_bit,
    output logic [DATA_W-1:0] enc_est,
    input  logic              dec_en,
    input  logic              rx_bit,
    output logic [DATA_W-1:0] dec_out
);
    logic signed [DATA_W-1:0] enc_est_s, dec_out_s;

    slope_enc #(
        .DATA_W(DATA_W), .HIST(HIST), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
    ) u_enc (
        .clk(clk), .rst(rst), .en(enc_en), .pcm_in($signed(pcm_in)),
        .bit_out(tx_bit), .est(enc_est_s)
    );

    slope_dec #(
        .DATA_W(DATA_W), .HIST(HIST), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
    ) u_dec (
        .clk(clk), .rst(rst), .en(dec_en), .bit_in(rx_bit), .recon(dec_out_s)
    );

    assign enc_est = enc_est_s;
    assign dec_out = dec_out_s;

    // R1: reset leaves both integrators at zero
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (enc_est == '0 && dec_out == '0 && tx_bit == 1'b0));
endmodule

// File: tb/slope_codec_bench.sv
module slope_codec_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1, enc_en = 1'b0, dec_en = 1'b0, rx_bit = 1'b0;
    logic [15:0] pcm_in = '0;
    logic        tx_bit;
    logic [15:0] enc_est, dec_out;

    slope_codec u_slope_codec (
        .clk(clk), .rst(rst), .enc_en(enc_en), .pcm_in(pcm_in),
        .tx_bit(tx_bit), .enc_est(enc_est), .dec_en(dec_en),
        .rx_bit(rx_bit), .dec_out(dec_out)
    );

    typedef struct { logic b; int e; } exp_t;
    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    int m_est, m_step, m_hist;
    logic prev_bit;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_est = 0; m_step = 16; m_hist = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; enc_en = 1'b0; dec_en = 1'b0;
        @(negedge clk); rst = 1'b0;
        model_reset();
    endtask

    // driver: one encoder sample then one decoder sample
    task automatic sample(input int v);
        logic b;
        @(negedge clk);
        pcm_in = 16'(v); enc_en = 1'b1;
        b = (v >= m_est);
        m_hist = ((m_hist << 1) | int'(b)) & 7;
        if (m_hist == 7 || m_hist == 0) m_step = (m_step * 2 > 4096) ? 4096 : m_step * 2;
        else                             m_step = (m_step / 2 < 16) ? 16 : m_step / 2;
        m_est = b ? m_est + m_step : m_est - m_step;
        if (m_est > 32767)  m_est = 32767;
        if (m_est < -32768) m_est = -32768;
        @(posedge clk); #1;
        q.push_back('{b, m_est});
        @(negedge clk);
        enc_en = 1'b0; rx_bit = tx_bit; dec_en = 1'b1;
        @(negedge clk);
        dec_en = 1'b0;
        chk(dec_out == enc_est, "R8 decoder matches encoder",
            int'($signed(dec_out)), int'($signed(enc_est)));
    endtask

    // monitor: compare scoreboard items one cycle after each encoder enable
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(tx_bit == e.b, "R2 coded bit", int'(tx_bit), int'(e.b));
            chk(int'($signed(enc_est)) == e.e, "R3/R4/R5 estimate",
                int'($signed(enc_est)), e.e);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk(enc_est == 0, "R1 enc_est reset", int'(enc_est), 0);
        chk(dec_out == 0, "R1 dec_out reset", int'(dec_out), 0);
        chk(tx_bit == 0,  "R1 tx_bit reset", int'(tx_bit), 0);

        // R9: constant zero input alternates
        prev_bit = 1'b0;
        for (int i = 0; i < 12; i++) begin
            sample(0);
            if (i > 0) chk(tx_bit != prev_bit, "R9 alternation", int'(tx_bit), int'(!prev_bit));
            prev_bit = tx_bit;
        end

        // R7: enables low, inputs wiggle, outputs hold
        begin
            logic [15:0] e0, d0; logic t0;
            e0 = enc_est; d0 = dec_out; t0 = tx_bit;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk); pcm_in = 16'(i * 9000); rx_bit = i[0];
            end
            @(negedge clk);
            chk(enc_est == e0, "R7 enc hold", int'(enc_est), int'(e0));
            chk(dec_out == d0, "R7 dec hold", int'(dec_out), int'(d0));
            chk(tx_bit == t0,  "R7 bit hold", int'(tx_bit), int'(t0));
        end

        // R4 growth, R5 shrink
        do_reset();
        for (int i = 0; i < 5; i++) sample(32767);
        chk($signed(enc_est) == 256, "R4 step doubling", int'($signed(enc_est)), 256);
        sample(-32768);
        chk($signed(enc_est) == 192, "R5 step halving", int'($signed(enc_est)), 192);

        // R6 saturation both ways
        do_reset();
        for (int i = 0; i < 30; i++) sample(32767);
        chk($signed(enc_est) == 32767, "R6 positive saturation", int'($signed(enc_est)), 32767);
        for (int i = 0; i < 30; i++) sample(-32768);
        chk($signed(enc_est) < 0, "R6 no wrap on negative run", int'($signed(enc_est)), -32768);

        // R1 again after activity
        do_reset();
        chk(enc_est == 0 && dec_out == 0, "R1 re-reset", int'(enc_est), 0);

        // R10 slow ramp tracking
        for (int i = 0; i < 200; i++) begin
            int v; int d;
            v = -800 + 8 * i;
            sample(v);
            d = int'($signed(dec_out)) - v;
            if (i > 20) chk(d <= 200 && d >= -200, "R10 ramp tracking", int'($signed(dec_out)), v);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule